// File: doc/BRIEF.md
# USB Serial Engine Status and Device Address Register

This block is the status and control byte that a microcontroller uses to follow a USB serial interface engine. It holds the device address that the engine answers to. The address is applied in one of two ways. In immediate mode it changes as soon as firmware writes it. In deferred mode it is held back until the host has collected the IN data of the status stage. Deferred mode lets firmware write the new address while it is still handling SET_ADDRESS, and the old address stays in use until that transfer has finished.

The same byte gathers sticky event flags from the serial engine: FIFO access errors, received OUT data, link-level errors and NAK replies. It also shows whether a token is being received and whether that token is an IN. A NAK reply raises a one-cycle interrupt pulse unless the mask bit in the byte is set. Packet decoding and the transceiver lie outside this block. The block sees only single-cycle event pulses from the engine.

The status byte is laid out as follows: bit 0 address mode, bit 1 FIFO error, bit 2 OUT data received, bit 3 IN token in progress, bit 4 NAK sent, bit 5 link error, bit 6 token idle (active low busy), bit 7 NAK interrupt mask.

Top module: `sie_stat_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40, the device address is 0 and the interrupt output is low.
- R2: With bit 0 at 0, a pending-address write sets the device address to the written value on the next clock edge.
- R3: With bit 0 at 1, a written address is held and the device address does not change until an IN-acknowledge pulse. The held value is applied on that pulse. A write in the same cycle as an acknowledge is held for the next acknowledge. An acknowledge with nothing held leaves the address unchanged.
- R4: Bit 1 sets on a FIFO error pulse. A status write with bit 1 at 0 clears it and a write with bit 1 at 1 leaves it unchanged. A set in the same cycle as a clear leaves it at 1.
- R5: Bit 2 sets on OUT data with a nonzero length and not on zero-length OUT data. A SETUP pulse or a status write with bit 2 at 0 clears it. A set in the same cycle as a clear leaves it at 1.
- R6: Bit 5 sets on a CRC, PID or incomplete-token error pulse. It obeys the same write-0-clears, write-1-keeps and set-wins rules as bit 1.
- R7: Bit 6 reads 0 from the edge after a token-start pulse until the edge after a token-done pulse, and 1 otherwise. Bit 3 reads 1 only while a token is in progress whose start pulse marked it as IN.
- R8: Bit 4 sets on a NAK-sent pulse and is cleared by the next token-start pulse. A NAK in the same cycle as a token start leaves it set.
- R9: With bit 7 at 0, each NAK-sent pulse makes the interrupt output high for exactly the following cycle. With bit 7 at 1, NAK pulses leave the interrupt output low.
- R10: Bits 0 and 7 read back the value last written to them.
- R11: Writes have no effect on bits 3, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | 8 | Status byte write data |
| reg_rdata | output | 8 | Status byte read value |
| addr_wr | input | 1 | Pending-address write strobe |
| addr_wdata | input | ADDR_W | Pending-address value |
| tok_start | input | 1 | Token reception begins |
| tok_is_in | input | 1 | Token that begins is an IN token |
| tok_done | input | 1 | Token reception ends |
| ev_setup | input | 1 | Valid SETUP token received |
| ev_out_rx | input | 1 | OUT data packet received |
| ev_out_nz | input | 1 | Received OUT packet has a nonzero length |
| ev_nak | input | 1 | Engine replied with a NAK |
| ev_in_ack | input | 1 | Host acknowledged IN data |
| ev_fifo_err | input | 1 | Endpoint 0 FIFO access error |
| ev_link_err | input | 1 | CRC, PID or incomplete-token error |
| dev_addr | output | ADDR_W | Active device address |
| nak_irq | output | 1 | NAK interrupt pulse |

## Verification
The hardest case to reach is the deferred address path when a new pending write lands in the same cycle as an IN acknowledge. The acknowledge must apply nothing, and the new value must wait for the next acknowledge. The bench reaches this case by switching to deferred mode and first draining any held address. It then drives the write and the acknowledge in one cycle. The set-against-clear collisions on each sticky flag are swept over every combination of prior state, event pulse and written bit.

// File: rtl/sie_stat_pkg.sv
package sie_stat_pkg;

    parameter int unsigned STAT_W = 8;

    // Bit positions inside the status byte (firmware decodes these)
    localparam int unsigned B_MODE  = 0;
    localparam int unsigned B_FERR  = 1;
    localparam int unsigned B_OUT   = 2;
    localparam int unsigned B_INTOK = 3;
    localparam int unsigned B_NAK   = 4;
    localparam int unsigned B_LERR  = 5;
    localparam int unsigned B_IDLE  = 6;
    localparam int unsigned B_MASK  = 7;

    // Sticky flag indices in the flag bank
    typedef enum int unsigned {
        FL_FERR = 0,
        FL_OUT  = 1,
        FL_LERR = 2,
        FL_NAK  = 3
    } flag_idx_e;

    localparam int unsigned NUM_FLAGS = 4;

    typedef struct packed {
        logic nak_mask;
        logic tok_idle;
        logic link_err;
        logic nak_sent;
        logic in_tok;
        logic out_rx;
        logic fifo_err;
        logic defer_mode;
    } stat_t;

    function automatic stat_t build_stat(
        input logic                 defer_mode,
        input logic                 nak_mask,
        input logic [NUM_FLAGS-1:0] flags,
        input logic                 tok_busy,
        input logic                 in_tok
    );
        stat_t s;
        s.defer_mode = defer_mode;
        s.fifo_err   = flags[FL_FERR];
        s.out_rx     = flags[FL_OUT];
        s.in_tok     = in_tok;
        s.nak_sent   = flags[FL_NAK];
        s.link_err   = flags[FL_LERR];
        s.tok_idle   = ~tok_busy;
        s.nak_mask   = nak_mask;
        return s;
    endfunction

endpackage

// File: rtl/sie_flag_bank.sv
module sie_flag_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] q
);

    // Each flag: set has priority over either clear source
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (hw_set[i]) begin
                q[i] <= 1'b1;
            end else if (hw_clr[i] || sw_clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sie_addr_unit.sv
module sie_addr_unit #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              defer_mode,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              in_ack,
    output logic [ADDR_W-1:0] dev_addr
);

    logic [ADDR_W-1:0] pend_addr;
    logic              pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_addr  <= '0;
            pend_addr <= '0;
            pend_vld  <= 1'b0;
        end else begin
            // Acknowledge consumes whatever was held before this cycle
            if (in_ack && pend_vld) begin
                dev_addr <= pend_addr;
                pend_vld <= 1'b0;
            end
            // A write in this cycle takes effect afterwards
            if (addr_wr) begin
                if (defer_mode) begin
                    pend_addr <= addr_wdata;
                    pend_vld  <= 1'b1;
                end else begin
                    dev_addr <= addr_wdata;
                    pend_vld <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sie_token_track.sv
module sie_token_track (
    input  logic clk,
    input  logic rst,
    input  logic tok_start,
    input  logic tok_is_in,
    input  logic tok_done,
    output logic busy,
    output logic in_tok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            in_tok <= 1'b0;
        end else if (tok_start) begin
            busy   <= 1'b1;
            in_tok <= tok_is_in;
        end else if (tok_done) begin
            busy   <= 1'b0;
            in_tok <= 1'b0;
        end
    end

endmodule

// File: rtl/sie_stat_ctrl.sv
module sie_stat_ctrl
    import sie_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [STAT_W-1:0]   reg_wdata,
    output logic [STAT_W-1:0]   reg_rdata,
    input  logic                addr_wr,
    input  logic [ADDR_W-1:0]   addr_wdata,
    input  logic                tok_start,
    input  logic                tok_is_in,
    input  logic                tok_done,
    input  logic                ev_setup,
    input  logic                ev_out_rx,
    input  logic                ev_out_nz,
    input  logic                ev_nak,
    input  logic                ev_in_ack,
    input  logic                ev_fifo_err,
    input  logic                ev_link_err,
    output logic [ADDR_W-1:0]   dev_addr,
    output logic                nak_irq
);

    logic                 defer_mode;
    logic                 nak_mask;
    logic [NUM_FLAGS-1:0] hw_set;
    logic [NUM_FLAGS-1:0] hw_clr;
    logic [NUM_FLAGS-1:0] sw_clr;
    logic [NUM_FLAGS-1:0] flags;
    logic                 tok_busy;
    logic                 in_tok;
    stat_t                stat;

    // Plain control bits
    always_ff @(posedge clk) begin
        if (rst) begin
            defer_mode <= 1'b0;
            nak_mask   <= 1'b0;
        end else if (reg_wr) begin
            defer_mode <= reg_wdata[B_MODE];
            nak_mask   <= reg_wdata[B_MASK];
        end
    end

    // Flag event routing
    always_comb begin
        hw_set          = '0;
        hw_clr          = '0;
        sw_clr          = '0;
        hw_set[FL_FERR] = ev_fifo_err;
        hw_set[FL_OUT]  = ev_out_rx & ev_out_nz;
        hw_set[FL_LERR] = ev_link_err;
        hw_set[FL_NAK]  = ev_nak;
        hw_clr[FL_OUT]  = ev_setup;
        hw_clr[FL_NAK]  = tok_start;
        sw_clr[FL_FERR] = reg_wr & ~reg_wdata[B_FERR];
        sw_clr[FL_OUT]  = reg_wr & ~reg_wdata[B_OUT];
        sw_clr[FL_LERR] = reg_wr & ~reg_wdata[B_LERR];
    end

    sie_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .hw_set (hw_set),
        .hw_clr (hw_clr),
        .sw_clr (sw_clr),
        .q      (flags)
    );

    sie_token_track u_tok (
        .clk       (clk),
        .rst       (rst),
        .tok_start (tok_start),
        .tok_is_in (tok_is_in),
        .tok_done  (tok_done),
        .busy      (tok_busy),
        .in_tok    (in_tok)
    );

    sie_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .defer_mode (defer_mode),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .in_ack     (ev_in_ack),
        .dev_addr   (dev_addr)
    );

    // One pulse per unmasked NAK
    always_ff @(posedge clk) begin
        if (rst) nak_irq <= 1'b0;
        else     nak_irq <= ev_nak & ~nak_mask;
    end

    always_comb begin
        stat      = build_stat(defer_mode, nak_mask, flags, tok_busy, in_tok);
        reg_rdata = stat;
    end

endmodule

// File: rtl/sie_stat_chk.sv
module sie_stat_chk #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              addr_wr,
    input logic [ADDR_W-1:0] addr_wdata,
    input logic              tok_start,
    input logic              tok_done,
    input logic              ev_nak,
    input logic              ev_in_ack,
    input logic              ev_link_err,
    input logic              ev_fifo_err,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              nak_irq
);

    p_addr_now_r2: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !reg_rdata[0]) |=> (dev_addr == $past(addr_wdata)));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && !ev_in_ack) |=> $stable(dev_addr));

    p_ferr_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && !(reg_wr && !reg_wdata[1])) |=> reg_rdata[1]);

    p_ferr_set_r4: assert property (@(posedge clk) disable iff (rst)
        ev_fifo_err |=> reg_rdata[1]);

    p_lerr_set_r6: assert property (@(posedge clk) disable iff (rst)
        ev_link_err |=> reg_rdata[5]);

    p_tok_busy_r7: assert property (@(posedge clk) disable iff (rst)
        tok_start |=> !reg_rdata[6]);

    p_tok_end_r7: assert property (@(posedge clk) disable iff (rst)
        (tok_done && !tok_start) |=> (reg_rdata[6] && !reg_rdata[3]));

    p_irq_on_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_nak && !reg_rdata[7]) |=> nak_irq);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
        !ev_nak |=> !nak_irq);

endmodule

bind sie_stat_ctrl sie_stat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .addr_wr     (addr_wr),
    .addr_wdata  (addr_wdata),
    .tok_start   (tok_start),
    .tok_done    (tok_done),
    .ev_nak      (ev_nak),
    .ev_in_ack   (ev_in_ack),
    .ev_link_err (ev_link_err),
    .ev_fifo_err (ev_fifo_err),
    .dev_addr    (dev_addr),
    .nak_irq     (nak_irq)
);

// File: tb/sim_sie_stat_ctrl.sv
module sim_sie_stat_ctrl;

    localparam int unsigned AW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          addr_wr = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic          tok_start = 1'b0, tok_is_in = 1'b0, tok_done = 1'b0;
    logic          ev_setup = 1'b0, ev_out_rx = 1'b0, ev_out_nz = 1'b0;
    logic          ev_nak = 1'b0, ev_in_ack = 1'b0;
    logic          ev_fifo_err = 1'b0, ev_link_err = 1'b0;
    logic [AW-1:0] dev_addr;
    logic          nak_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sie_stat_ctrl #(.ADDR_W(AW)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, advance one edge, release pulses
    task automatic step();
        @(negedge clk);
        reg_wr = 0; addr_wr = 0; tok_start = 0; tok_done = 0; tok_is_in = 0;
        ev_setup = 0; ev_out_rx = 0; ev_out_nz = 0; ev_nak = 0;
        ev_in_ack = 0; ev_fifo_err = 0; ev_link_err = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d; step();
    endtask

    task automatic pulse_flag(input int sel);
        if (sel == 1) ev_fifo_err = 1; else ev_link_err = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", reg_rdata, 8'h40);
        chk("R1 addr", dev_addr, 0);
        chk("R1 irq", nak_irq, 0);

        // R10 control bits read back
        wr(8'h81); chk("R10 mode+mask", reg_rdata, 8'hC1);
        wr(8'h00); chk("R10 cleared", reg_rdata, 8'h40);
        // R11 read-only bits ignore writes
        wr(8'h58); chk("R11 ro bits", reg_rdata & 8'h58, 8'h40);
        wr(8'h00);

        // R2 immediate mode: sweep all addresses
        for (int a = 0; a < (1 << AW); a++) begin
            addr_wr = 1; addr_wdata = AW'(a); step();
            chk("R2 immediate addr", dev_addr, a);
        end

        // R3 deferred mode
        wr(8'h01);
        addr_wr = 1; addr_wdata = 7'h2A; step();
        for (int k = 0; k < 3; k++) begin
            chk("R3 held", dev_addr, 7'h7F);
            step();
        end
        ev_in_ack = 1; step();
        chk("R3 applied on ack", dev_addr, 7'h2A);
        ev_in_ack = 1; step();
        chk("R3 ack without pending", dev_addr, 7'h2A);
        addr_wr = 1; addr_wdata = 7'h15; ev_in_ack = 1; step();
        chk("R3 write with ack held", dev_addr, 7'h2A);
        ev_in_ack = 1; step();
        chk("R3 next ack applies", dev_addr, 7'h15);
        wr(8'h00);

        // R4 / R6 sticky flag sweep: prior x set x clear
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 8; c++) begin
                automatic int bitp = (f == 0) ? 1 : 5;
                automatic int pre = c & 1, st = (c >> 1) & 1, clr = (c >> 2) & 1;
                automatic logic [7:0] d = 8'hFF;
                wr(8'h00);
                if (pre != 0) begin pulse_flag(bitp); step(); end
                if (st != 0) pulse_flag(bitp);
                d[bitp] = (clr == 0);
                wr(d & 8'h7E);
                chk(f == 0 ? "R4 fifo err flag" : "R6 link err flag",
                    reg_rdata[bitp], st | (pre & ~clr));
            end
        end
        wr(8'h00);

        // R5 OUT flag
        ev_out_rx = 1; ev_out_nz = 0; step();
        chk("R5 zero length ignored", reg_rdata[2], 0);
        ev_out_rx = 1; ev_out_nz = 1; step();
        chk("R5 nonzero sets", reg_rdata[2], 1);
        ev_setup = 1; step();
        chk("R5 setup clears", reg_rdata[2], 0);
        ev_out_rx = 1; ev_out_nz = 1; ev_setup = 1; step();
        chk("R5 set beats setup", reg_rdata[2], 1);
        wr(8'h04); chk("R5 write1 keeps", reg_rdata[2], 1);
        wr(8'h00); chk("R5 write0 clears", reg_rdata[2], 0);

        // R7 token activity
        tok_start = 1; tok_is_in = 1; step();
        chk("R7 busy IN", reg_rdata & 8'h48, 8'h08);
        tok_done = 1; step();
        chk("R7 idle", reg_rdata & 8'h48, 8'h40);
        tok_start = 1; tok_is_in = 0; step();
        chk("R7 busy not IN", reg_rdata & 8'h48, 8'h00);
        tok_done = 1; step();

        // R8 NAK status flag
        ev_nak = 1; step();
        chk("R8 nak set", reg_rdata[4], 1);
        step();
        chk("R8 nak sticky", reg_rdata[4], 1);
        tok_start = 1; step();
        chk("R8 cleared by token", reg_rdata[4], 0);
        tok_done = 1; ev_nak = 1; tok_start = 1; step();
        chk("R8 nak beats token start", reg_rdata[4], 1);
        tok_done = 1; step();

        // R9 interrupt
        ev_nak = 1; step();
        chk("R9 irq pulse", nak_irq, 1);
        step();
        chk("R9 irq one cycle", nak_irq, 0);
        ev_nak = 1; step();
        ev_nak = 1; chk("R9 back to back 1", nak_irq, 1); step();
        chk("R9 back to back 2", nak_irq, 1);
        step();
        chk("R9 back to back end", nak_irq, 0);
        wr(8'h80);
        ev_nak = 1; step();
        chk("R9 masked", nak_irq, 0);
        step();
        chk("R9 masked later", nak_irq, 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=0x0 expected=0x1");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule